// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block turns a fast reference clock into a slow clock whose average rate falls between two integer divisions of the reference. It runs a first ratio for a programmed number of output periods, then a second ratio for its own programmed number of periods, and repeats. Averaged over the cycle, the output frequency lies between the two plain quotients. A 24 MHz crystal can give a close 32.768 kHz this way.

Two 32-bit control words carry the two ratios, the two repeat counts and four mode bits: dual mode, bypass, an input gate and an output gate. The input gate freezes the divider and returns it to a clean starting point. The output gate masks the result without cutting a pulse short. The intended reprogramming order is: close both gates, write the ratios, open the input gate, then open the output gate. In bypass the reference clock itself leaves the block.

Top module: `frac_clk_div`

## Requirements
- R1: Control word 0 carries ratio field A in bits 11:0 and ratio field B in bits 23:12. Bit 28 selects dual mode, bit 30 enables the output gate and bit 31 enables the input gate. Each effective ratio is its field value plus one.
- R2: Control word 1 carries repeat field A in bits 11:0 and repeat field B in bits 23:12, and bit 24 selects bypass. Each effective repeat count is its field value plus one.
- R3: With dual mode off, every output period lasts ratio A reference cycles, and ratio B and both repeat fields have no effect on the output.
- R4: With dual mode on, the output gives repeat-A periods at ratio A, then repeat-B periods at ratio B, and repeats this pattern. Each run of the pattern starts with ratio A.
- R5: An output period of ratio N is high for floor(N/2) reference cycles and then low for the remaining cycles. A ratio of 1 gives a steady low output.
- R6: A change of ratio fields or mode takes effect only at the next output-period boundary. The period in progress completes at its old length.
- R7: While the input gate is off, the output is low and the divider returns to the start of a ratio-A phase. Reopening the gate begins with a full ratio-A period.
- R8: While the output gate is off, the output is held low. The gate setting is taken only while the divided waveform is low, so no high pulse is ever shortened.
- R9: With bypass set, the output follows the reference clock whatever the other fields hold.
- R10: With ratios 733 and 732 and repeat counts 8 and 11, one full pattern of 19 periods spans 13916 reference cycles, which is 32768 Hz from 24 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl0_i | input | 32 | Ratio fields, dual-mode bit and both gate bits |
| ctrl1_i | input | 32 | Repeat fields and bypass bit |
| clk_o | output | 1 | Divided (or bypassed) clock |

## Verification
The hardest case to reach from the ports is a gate change that lands while the divided waveform is high. If that change were taken at once, it would produce a runt pulse. The stimulus first locks onto a rising edge of the output and then closes the output gate in that same cycle. It reopens the gate after a random delay, so the reopening can fall inside a high phase that the output cannot yet show. After each of these, the length of the next pulse is measured. Random ratio and repeat patterns are checked one period at a time against a list of expected lengths built from the requirements. Directed cases cover a ratio change in mid-period, gating that resets the phase of a dual-mode pattern, and the 19-period pattern of the 24 MHz example.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned FLD_W   = 12;
  localparam int unsigned N_PH    = 2;   // ratio A, ratio B
  // mode bit positions
  localparam int unsigned B_DUAL  = 28;
  localparam int unsigned B_OGATE = 30;
  localparam int unsigned B_IGATE = 31;
  localparam int unsigned B_BYP   = 24;
endpackage

// File: rtl/fd_phase_seq.sv
module fd_phase_seq #(
  parameter int unsigned FW   = 12,
  parameter int unsigned NPH  = 2,
  localparam int unsigned RW  = FW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dual_i,
  input  logic          end_i,
  input  logic [FW-1:0] n_fld_i [NPH],
  input  logic [FW-1:0] m_fld_i [NPH],
  output logic          sel_o,
  output logic [RW-1:0] next_n_o
);
  logic          sel_q;
  logic [FW-1:0] rep_q;
  logic          last_rep;
  logic          other;

  assign other    = ~sel_q;
  // >= guards against a repeat field shrinking below the running count
  assign last_rep = rep_q >= m_fld_i[sel_q];
  assign sel_o    = sel_q;

  always_comb begin
    if (!en_i || !dual_i)  next_n_o = RW'(n_fld_i[0]) + RW'(1);
    else if (last_rep)     next_n_o = RW'(n_fld_i[other]) + RW'(1);
    else                   next_n_o = RW'(n_fld_i[sel_q]) + RW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      rep_q <= '0;
    end else if (!en_i) begin
      sel_q <= 1'b0;
      rep_q <= '0;
    end else if (end_i) begin
      if (!dual_i) begin
        sel_q <= 1'b0;
        rep_q <= '0;
      end else if (last_rep) begin
        sel_q <= other;
        rep_q <= '0;
      end else begin
        rep_q <= rep_q + FW'(1);
      end
    end
  end

  p_sel_change_at_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> ($past(end_i) || !$past(en_i)));

  p_single_stays_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dual_i && end_i) |=> !sel_q);
endmodule

// File: rtl/fd_period_ctr.sv
module fd_period_ctr #(
  parameter int unsigned FW  = 12,
  localparam int unsigned RW = FW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [RW-1:0] next_n_i,
  output logic          end_o,
  output logic          raw_o
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] n_cur_q;

  assign end_o = en_i && (cnt_q == n_cur_q - RW'(1));
  assign raw_o = en_i && (cnt_q < (n_cur_q >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      n_cur_q <= RW'(1);
    end else if (!en_i) begin
      cnt_q   <= '0;
      n_cur_q <= next_n_i;   // preload ratio A for a clean restart
    end else if (end_o) begin
      cnt_q   <= '0;
      n_cur_q <= next_n_i;
    end else begin
      cnt_q   <= cnt_q + RW'(1);
    end
  end

  p_cnt_below_ratio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < n_cur_q));

  p_ratio_held_in_period_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !end_o) |=> (n_cur_q == $past(n_cur_q)));
endmodule

// File: rtl/fd_out_gate.sv
module fd_out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic gate_en_i,
  output logic out_o
);
  logic gate_q;
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (!raw_i) gate_q <= gate_en_i;   // sample only in low phase
      out_q <= raw_i & gate_q;
    end
  end

  assign out_o = out_q;

  p_gate_change_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q != $past(gate_q)) |-> !$past(raw_i));

  p_out_low_gate_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_q |=> !out_q);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int unsigned FW = FLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl0_i,
  input  logic [CTRL_W-1:0] ctrl1_i,
  output logic              clk_o
);
  localparam int unsigned RW = FW + 1;

  logic [FW-1:0] n_fld [N_PH];
  logic [FW-1:0] m_fld [N_PH];
  logic          in_en, out_en, dual, bypass;
  logic          end_w, raw_w, sel_w, div_q;
  logic [RW-1:0] next_n;
  logic          unused_ctrl;

  for (genvar g = 0; g < N_PH; g++) begin : g_fld
    assign n_fld[g] = ctrl0_i[g*FW +: FW];
    assign m_fld[g] = ctrl1_i[g*FW +: FW];
  end

  assign in_en       = ctrl0_i[B_IGATE];
  assign out_en      = ctrl0_i[B_OGATE];
  assign dual        = ctrl0_i[B_DUAL];
  assign bypass      = ctrl1_i[B_BYP];
  assign unused_ctrl = ^{ctrl0_i, ctrl1_i, sel_w};

  fd_phase_seq #(.FW(FW), .NPH(N_PH)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (in_en),
    .dual_i   (dual),
    .end_i    (end_w),
    .n_fld_i  (n_fld),
    .m_fld_i  (m_fld),
    .sel_o    (sel_w),
    .next_n_o (next_n)
  );

  fd_period_ctr #(.FW(FW)) i_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (in_en),
    .next_n_i (next_n),
    .end_o    (end_w),
    .raw_o    (raw_w)
  );

  fd_out_gate i_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (raw_w),
    .gate_en_i (out_en),
    .out_o     (div_q)
  );

  assign clk_o = bypass ? clk_i : div_q;

  p_idle_when_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_en |=> !div_q);
endmodule

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl0 = '0;
  logic [31:0] ctrl1 = '0;
  logic        clk_o;
  logic        s = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk_i = ~clk_i;

  frac_clk_div i_frac_clk_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl0_i(ctrl0), .ctrl1_i(ctrl1), .clk_o(clk_o)
  );

  function automatic void summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endfunction

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R1 and R2 field encodings
  function automatic logic [31:0] mk0(int n1, int n2, bit dual, bit og, bit ig);
    logic [31:0] w = '0;
    w[11:0] = 12'(n1 - 1); w[23:12] = 12'(n2 - 1);
    w[28] = dual; w[30] = og; w[31] = ig;
    return w;
  endfunction

  function automatic logic [31:0] mk1(int m1, int m2, bit byp);
    logic [31:0] w = '0;
    w[11:0] = 12'(m1 - 1); w[23:12] = 12'(m2 - 1); w[24] = byp;
    return w;
  endfunction

  function automatic int ratio_at(int i, int n1, int n2, int m1, int m2, bit dual);
    if (!dual) return n1;
    return ((i % (m1 + m2)) < m1) ? n1 : n2;
  endfunction

  task automatic step();
    @(negedge clk_i);
    s = clk_o;
  endtask

  task automatic meas(output int h, output int l);
    int lim = 0;
    h = 0; l = 0;
    while (!s && lim < 6000) begin step(); lim++; end
    while (s && h < 6000) begin h++; step(); end
    while (!s && l < 6000) begin l++; step(); end
  endtask

  task automatic start(int n1, int n2, int m1, int m2, bit dual);
    ctrl0 = mk0(n1, n2, dual, 1'b1, 1'b0);
    ctrl1 = mk1(m1, m2, 1'b0);
    repeat (3) step();
    ctrl0[31] = 1'b1;
  endtask

  task automatic run_pattern(int n1, int n2, int m1, int m2, bit dual, int periods, string req);
    int h, l, e;
    start(n1, n2, m1, m2, dual);
    for (int i = 0; i < periods; i++) begin
      meas(h, l);
      e = ratio_at(i, n1, n2, m1, m2, dual);
      check(h + l == e, req, h + l, e);
      check(h == e / 2, "R5 high", h, e / 2);
    end
    ctrl0[31] = 1'b0;
    step();
  endtask

  initial begin
    int h, l, cnt, sum;
    void'($urandom(32'd1234));
    repeat (3) step();
    check(s == 1'b0, "R8 reset low", s, 0);
    rst_ni = 1'b1;
    step();

    // single mode, other fields nonzero (R3, R1)
    run_pattern(10, 3, 2, 5, 1'b0, 6, "R1/R3");
    // dual mode directed (R4, R2)
    run_pattern(6, 9, 2, 3, 1'b1, 12, "R2/R4");
    // odd ratio
    run_pattern(7, 4, 1, 1, 1'b1, 6, "R4 odd");

    for (int k = 0; k < 8; k++) begin
      int n1 = 2 + int'($urandom % 23);
      int n2 = 2 + int'($urandom % 23);
      int m1 = 1 + int'($urandom % 4);
      int m2 = 1 + int'($urandom % 4);
      bit du = 1'($urandom % 2);
      run_pattern(n1, n2, m1, m2, du, du ? 2 * (m1 + m2) + 1 : 5, du ? "R4 rand" : "R3 rand");
    end

    // R5: ratio 1 stays low
    start(1, 5, 1, 1, 1'b0);
    cnt = 0;
    repeat (40) begin step(); cnt += int'(s); end
    check(cnt == 0, "R5 ratio one", cnt, 0);
    ctrl0[31] = 1'b0; step();

    // R6: ratio change mid-period
    start(10, 2, 1, 1, 1'b0);
    meas(h, l);
    ctrl0[11:0] = 12'(20 - 1);
    meas(h, l);
    check(h + l == 10, "R6 old period", h + l, 10);
    meas(h, l);
    check(h + l == 20, "R6 new period", h + l, 20);
    ctrl0[31] = 1'b0; step();

    // R8: output gate closed during a high phase
    start(12, 2, 1, 1, 1'b0);
    meas(h, l);
    ctrl0[30] = 1'b0;
    h = 0;
    while (s && h < 100) begin h++; step(); end
    check(h == 6, "R8 pulse kept", h, 6);
    cnt = 0;
    repeat (40) begin step(); cnt += int'(s); end
    check(cnt == 0, "R8 held low", cnt, 0);
    repeat (int'($urandom % 12)) step();
    ctrl0[30] = 1'b1;
    meas(h, l);
    check(h == 6, "R8 no runt high", h, 6);
    check(h + l == 12, "R8 no runt period", h + l, 12);
    ctrl0[31] = 1'b0; step();

    // R7: input gate resets a dual pattern to ratio A
    start(4, 7, 1, 3, 1'b1);
    meas(h, l);
    meas(h, l);
    check(h + l == 7, "R7 in phase B", h + l, 7);
    ctrl0[31] = 1'b0;
    cnt = 0;
    repeat (10) begin step(); cnt += int'(s); end
    check(cnt == 0, "R7 gated low", cnt, 0);
    ctrl0[31] = 1'b1;
    meas(h, l);
    check(h + l == 4 && h == 2, "R7 restart A", h + l, 4);
    meas(h, l);
    check(h + l == 7, "R7 then B", h + l, 7);
    ctrl0[31] = 1'b0; step();

    // R9: bypass follows the reference
    ctrl0 = mk0(5, 5, 1'b1, 1'b0, 1'b0);
    ctrl1 = mk1(2, 2, 1'b1);
    repeat (4) begin
      @(posedge clk_i); #1;
      check(clk_o == 1'b1, "R9 high", clk_o, 1);
      @(negedge clk_i); #1;
      check(clk_o == 1'b0, "R9 low", clk_o, 0);
    end
    ctrl1 = '0;
    step();

    // R10: 24 MHz to 32.768 kHz example
    start(733, 732, 8, 11, 1'b1);
    sum = 0;
    for (int i = 0; i < 19; i++) begin meas(h, l); sum += h + l; end
    check(sum == 13916, "R10 pattern span", sum, 13916);

    summary();
    $finish;
  end
endmodule